// File: doc/BRIEF.md
# General-Purpose Pin Bank with Input Filtering and Wake Detection

This block manages a bank of bidirectional chip pins. Each pin belongs either to software, which drives it through a small register file, or to a hardware function, which drives it through a dedicated alternate port. Pad controls leave the block as plain vectors: output enable, output value, pull-up enable and pull-down enable. Incoming pad levels are synchronised. They can then be cleaned by a per-pin glitch filter that runs on a slow tick. The cleaned levels go back to software and to the hardware function.

The cleaned levels feed an interrupt unit. Every pin can be set for edge or level detection, with its own polarity. Event flags are sticky and are cleared by writing ones. A separate wake-up detector compares the raw pad level with a programmed level for each pin. It has no registers in its path, so it works with the clock stopped and ignores the interrupt setup.

Registers are written with a single-cycle strobe and read back combinationally. Each register holds one bit per pin, except the filter-length register.

Top module: `gpio_bank`

## Requirements
- R1: After reset every writable register reads 0. `pad_oe_o`, `irq_o` and `wake_o` are 0.
- R2: When bit i of the owner register (address 2) is 1, pad i takes its output enable and output value from `hw_oe_i`/`hw_out_i`. When the bit is 0, they come from the direction register (address 0, 1 = drive) and the output register (address 1). A change shows one cycle after the write.
- R3: `pad_pd_o` equals the pull-down register (address 4). `pad_pu_o` equals the pull-up register (address 3) with every bit cleared where pull-down is also set.
- R4: With filtering off, the pin-level register (address 13, read only) and `hw_in_o` show a pad level two clock edges after it is applied.
- R5: With filter bit i set (address 5), a new level on pin i is accepted only after it differs from the held level on L+1 consecutive `tick_i` cycles. L is the 4-bit value in bits 3:0 of address 6. A shorter excursion is ignored and restarts the count.
- R6: A pin whose type bit (address 8) is 0 uses edge detection. Its polarity bit (address 9) selects a rising edge (1) or a falling edge (0) of the filtered level. The status bit is set one edge after the filtered level changes.
- R7: A pin whose type bit is 1 sets its status bit on every cycle in which its filtered level equals its polarity bit. A clear has no effect while that condition lasts.
- R8: The status bits (address 10) stay set until a 1 is written to them. Writing 0 leaves them unchanged.
- R9: `irq_o` is the OR of the status bits ANDed with the enable register (address 7). A set status bit whose enable is off does not raise `irq_o`.
- R10: `wake_o` is 1 when any pin with its wake-enable bit (address 11) set has a raw pad level equal to its wake-level bit (address 12). No clock edge is needed, and the interrupt registers have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Slow tick enable for the filters |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | NPINS | Write data |
| rdata_o | output | NPINS | Read data for `addr_i` |
| pad_in_i | input | NPINS | Raw pad levels |
| pad_oe_o | output | NPINS | Pad output enables |
| pad_out_o | output | NPINS | Pad output values |
| pad_pu_o | output | NPINS | Pull-up enables |
| pad_pd_o | output | NPINS | Pull-down enables |
| hw_oe_i | input | NPINS | Hardware-owned output enables |
| hw_out_i | input | NPINS | Hardware-owned output values |
| hw_in_o | output | NPINS | Filtered pin levels for the hardware function |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wake-up request, combinational |

## Verification
A wrong owner or direction bit shows on `pad_oe_o`/`pad_out_o` on the cycle after the write. A stale synchroniser or filter state shows in the pin-level register within two edges, or within L+1 ticks when filtering is on. A corrupted previous-level flop in the interrupt unit appears as a spurious or missing status bit one edge after the filtered level changes. A lost sticky bit drops `irq_o` with no clear written. Wake logic has no state, so any error shows on `wake_o` at once for the pad pattern that exposes it.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam logic [ADDR_W-1:0] A_DIR   = 4'd0;
  localparam logic [ADDR_W-1:0] A_DOUT  = 4'd1;
  localparam logic [ADDR_W-1:0] A_OWNER = 4'd2;
  localparam logic [ADDR_W-1:0] A_PU    = 4'd3;
  localparam logic [ADDR_W-1:0] A_PD    = 4'd4;
  localparam logic [ADDR_W-1:0] A_FLTEN = 4'd5;
  localparam logic [ADDR_W-1:0] A_FLTLEN= 4'd6;
  localparam logic [ADDR_W-1:0] A_IEN   = 4'd7;
  localparam logic [ADDR_W-1:0] A_ITYPE = 4'd8;
  localparam logic [ADDR_W-1:0] A_IPOL  = 4'd9;
  localparam logic [ADDR_W-1:0] A_ISTAT = 4'd10;
  localparam logic [ADDR_W-1:0] A_WEN   = 4'd11;
  localparam logic [ADDR_W-1:0] A_WLVL  = 4'd12;
  localparam logic [ADDR_W-1:0] A_PIN   = 4'd13;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_debounce.sv
module gpio_debounce #(
  parameter int unsigned W     = 8,
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [W-1:0]     en_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic [W-1:0]     d_i,
  output logic [W-1:0]     q_o
);
  for (genvar g = 0; g < W; g++) begin : g_pin
    logic [CNT_W-1:0] cnt_q;
    logic             held_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q  <= '0;
        held_q <= 1'b0;
      end else if (!en_i[g]) begin
        cnt_q  <= '0;
        held_q <= d_i[g];
      end else if (tick_i) begin
        if (d_i[g] != held_q) begin
          if (cnt_q >= len_i) begin
            held_q <= d_i[g];
            cnt_q  <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end else begin
          cnt_q <= '0;
        end
      end
    end

    assign q_o[g] = en_i[g] ? held_q : d_i[g];
  end
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] en_i,
  input  logic [W-1:0] type_i,
  input  logic [W-1:0] pol_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_o,
  output logic         irq_o
);
  logic [W-1:0] prev_q, stat_q;
  logic [W-1:0] rise, fall, edge_hit, lvl_hit, hit;

  always_comb begin
    rise     = lvl_i & ~prev_q;
    fall     = ~lvl_i & prev_q;
    edge_hit = (pol_i & rise) | (~pol_i & fall);
    lvl_hit  = ~(lvl_i ^ pol_i);
    hit      = (type_i & lvl_hit) | (~type_i & edge_hit);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      stat_q <= '0;
    end else begin
      prev_q <= lvl_i;
      stat_q <= (stat_q & ~clr_i) | hit;  // new event wins over clear
    end
  end

  assign stat_o = stat_q;
  assign irq_o  = |(stat_q & en_i);
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned W     = 8,
  parameter int unsigned CNT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      rdata_o,
  input  logic [W-1:0]      stat_i,
  input  logic [W-1:0]      pin_i,
  output logic [W-1:0]      dir_o,
  output logic [W-1:0]      dout_o,
  output logic [W-1:0]      owner_o,
  output logic [W-1:0]      pu_o,
  output logic [W-1:0]      pd_o,
  output logic [W-1:0]      flt_en_o,
  output logic [CNT_W-1:0]  flt_len_o,
  output logic [W-1:0]      ien_o,
  output logic [W-1:0]      itype_o,
  output logic [W-1:0]      ipol_o,
  output logic [W-1:0]      wen_o,
  output logic [W-1:0]      wlvl_o,
  output logic [W-1:0]      clr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_o     <= '0;
      dout_o    <= '0;
      owner_o   <= '0;
      pu_o      <= '0;
      pd_o      <= '0;
      flt_en_o  <= '0;
      flt_len_o <= '0;
      ien_o     <= '0;
      itype_o   <= '0;
      ipol_o    <= '0;
      wen_o     <= '0;
      wlvl_o    <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        A_DIR:    dir_o     <= wdata_i;
        A_DOUT:   dout_o    <= wdata_i;
        A_OWNER:  owner_o   <= wdata_i;
        A_PU:     pu_o      <= wdata_i;
        A_PD:     pd_o      <= wdata_i;
        A_FLTEN:  flt_en_o  <= wdata_i;
        A_FLTLEN: flt_len_o <= wdata_i[CNT_W-1:0];
        A_IEN:    ien_o     <= wdata_i;
        A_ITYPE:  itype_o   <= wdata_i;
        A_IPOL:   ipol_o    <= wdata_i;
        A_WEN:    wen_o     <= wdata_i;
        A_WLVL:   wlvl_o    <= wdata_i;
        default: ;
      endcase
    end
  end

  assign clr_o = (wr_en_i && addr_i == A_ISTAT) ? wdata_i : '0;

  always_comb begin
    case (addr_i)
      A_DIR:    rdata_o = dir_o;
      A_DOUT:   rdata_o = dout_o;
      A_OWNER:  rdata_o = owner_o;
      A_PU:     rdata_o = pu_o;
      A_PD:     rdata_o = pd_o;
      A_FLTEN:  rdata_o = flt_en_o;
      A_FLTLEN: rdata_o = W'(flt_len_o);
      A_IEN:    rdata_o = ien_o;
      A_ITYPE:  rdata_o = itype_o;
      A_IPOL:   rdata_o = ipol_o;
      A_ISTAT:  rdata_o = stat_i;
      A_WEN:    rdata_o = wen_o;
      A_WLVL:   rdata_o = wlvl_o;
      A_PIN:    rdata_o = pin_i;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_pkg::*;
#(
  parameter int unsigned NPINS = 8,
  parameter int unsigned CNT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NPINS-1:0]  wdata_i,
  output logic [NPINS-1:0]  rdata_o,
  input  logic [NPINS-1:0]  pad_in_i,
  output logic [NPINS-1:0]  pad_oe_o,
  output logic [NPINS-1:0]  pad_out_o,
  output logic [NPINS-1:0]  pad_pu_o,
  output logic [NPINS-1:0]  pad_pd_o,
  input  logic [NPINS-1:0]  hw_oe_i,
  input  logic [NPINS-1:0]  hw_out_i,
  output logic [NPINS-1:0]  hw_in_o,
  output logic              irq_o,
  output logic              wake_o
);
  logic [NPINS-1:0] dir_q, dout_q, owner_q, pu_q, pd_q, flt_en_q;
  logic [NPINS-1:0] ien_q, itype_q, ipol_q, wen_q, wlvl_q, clr;
  logic [NPINS-1:0] stat, synced, filt;
  logic [CNT_W-1:0] flt_len_q;

  gpio_regs #(.W(NPINS), .CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .rdata_o,
    .stat_i(stat), .pin_i(filt),
    .dir_o(dir_q), .dout_o(dout_q), .owner_o(owner_q), .pu_o(pu_q), .pd_o(pd_q),
    .flt_en_o(flt_en_q), .flt_len_o(flt_len_q), .ien_o(ien_q), .itype_o(itype_q),
    .ipol_o(ipol_q), .wen_o(wen_q), .wlvl_o(wlvl_q), .clr_o(clr)
  );

  gpio_sync #(.W(NPINS)) u_sync (
    .clk_i, .rst_ni, .d_i(pad_in_i), .q_o(synced)
  );

  gpio_debounce #(.W(NPINS), .CNT_W(CNT_W)) u_flt (
    .clk_i, .rst_ni, .tick_i, .en_i(flt_en_q), .len_i(flt_len_q),
    .d_i(synced), .q_o(filt)
  );

  gpio_irq #(.W(NPINS)) u_irq (
    .clk_i, .rst_ni, .lvl_i(filt), .en_i(ien_q), .type_i(itype_q),
    .pol_i(ipol_q), .clr_i(clr), .stat_o(stat), .irq_o(irq_o)
  );

  // pad muxing per ownership
  assign pad_oe_o  = (owner_q & hw_oe_i)  | (~owner_q & dir_q);
  assign pad_out_o = (owner_q & hw_out_i) | (~owner_q & dout_q);
  assign pad_pd_o  = pd_q;
  assign pad_pu_o  = pu_q & ~pd_q;
  assign hw_in_o   = filt;

  // clockless wake path from raw pads
  assign wake_o = |(wen_q & ~(pad_in_i ^ wlvl_q));
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_pkg::*;
#(
  parameter int unsigned NPINS = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [NPINS-1:0]  wdata_i,
  input logic [NPINS-1:0]  pad_in_i,
  input logic [NPINS-1:0]  pad_oe_o,
  input logic [NPINS-1:0]  pad_pu_o,
  input logic [NPINS-1:0]  pad_pd_o,
  input logic [NPINS-1:0]  hw_in_o,
  input logic              irq_o,
  input logic              wake_o,
  input logic [NPINS-1:0]  owner_q,
  input logic [NPINS-1:0]  flt_en_q
);
  assert_sw_dir_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_DIR && owner_q == '0) |=> (pad_oe_o == $past(wdata_i)));

  assert_pull_prio_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_PU) |=> (pad_pu_o == ($past(wdata_i) & ~pad_pd_o)));

  assert_flt_on_tick_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((hw_in_o ^ $past(hw_in_o)) & flt_en_q & $past(flt_en_q)) != '0) |-> $past(tick_i));

  assert_irq_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !(wr_en_i && (addr_i == A_ISTAT || addr_i == A_IEN))) |=> irq_o);

  assert_wake_static_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(wr_en_i) && $stable(pad_in_i)) |-> $stable(wake_o));
endmodule

bind gpio_bank gpio_bank_chk #(.NPINS(NPINS)) u_chk (
  .clk_i, .rst_ni, .tick_i, .wr_en_i, .addr_i, .wdata_i, .pad_in_i,
  .pad_oe_o, .pad_pu_o, .pad_pd_o, .hw_in_o, .irq_o, .wake_o,
  .owner_q, .flt_en_q
);

// File: tb/gpio_bank_tb_top.sv
module gpio_bank_tb_top;
  import gpio_pkg::*;
  localparam int unsigned N = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b0;
  logic wr_en_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [N-1:0] wdata_i = '0;
  logic [N-1:0] rdata_o;
  logic [N-1:0] pad_in_i = '0;
  logic [N-1:0] pad_oe_o, pad_out_o, pad_pu_o, pad_pd_o, hw_in_o;
  logic [N-1:0] hw_oe_i = '0;
  logic [N-1:0] hw_out_i = '0;
  logic irq_o, wake_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  gpio_bank #(.NPINS(N)) dut_i (
    .clk_i, .rst_ni, .tick_i, .wr_en_i, .addr_i, .wdata_i, .rdata_o,
    .pad_in_i, .pad_oe_o, .pad_out_o, .pad_pu_o, .pad_pd_o,
    .hw_oe_i, .hw_out_i, .hw_in_o, .irq_o, .wake_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [N-1:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [N-1:0] d);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      @(negedge clk_i); tick_i = 1'b1;
      @(negedge clk_i); tick_i = 1'b0;
    end
  endtask

  initial begin
    #(8 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [N-1:0] r;
    cyc(3);
    rst_ni = 1'b1;
    cyc(2);
    // R1 reset values
    for (int a = 0; a <= 13; a++) begin
      rd(ADDR_W'(a), r);
      chk("R1 reg", 32'(r), 32'h0);
    end
    chk("R1 oe", 32'(pad_oe_o), 32'h0);
    chk("R1 irq", 32'(irq_o), 32'h0);
    chk("R1 wake", 32'(wake_o), 32'h0);

    // R2 ownership and direction sweep
    for (int k = 0; k < 32; k++) begin
      logic [N-1:0] d, o, h, he, ho;
      d = N'(k * 37); o = N'(k * 91); h = N'(k * 53);
      he = N'(k * 13 + 5); ho = N'(k * 29 + 3);
      hw_oe_i = he; hw_out_i = ho;
      wr(A_DIR, d); wr(A_DOUT, o); wr(A_OWNER, h);
      #1;
      chk("R2 oe", 32'(pad_oe_o), 32'((h & he) | (~h & d)));
      chk("R2 out", 32'(pad_out_o), 32'((h & ho) | (~h & o)));
    end

    // R3 pull sweep
    for (int k = 0; k < 16; k++) begin
      logic [N-1:0] u, p;
      u = N'(k * 29); p = N'(k * 71);
      wr(A_PU, u); wr(A_PD, p);
      #1;
      chk("R3 pu", 32'(pad_pu_o), 32'(u & ~p));
      chk("R3 pd", 32'(pad_pd_o), 32'(p));
    end

    // R4 input path, filter off
    for (int k = 0; k < 16; k++) begin
      logic [N-1:0] v;
      v = N'(k * 43);
      @(negedge clk_i); pad_in_i = v;
      @(negedge clk_i);
      chk("R4 early", 32'(hw_in_o), 32'(N'((k - 1) * 43) & {N{k != 0}}));
      @(negedge clk_i);
      rd(A_PIN, r);
      chk("R4 pin", 32'(r), 32'(v));
      chk("R4 hw", 32'(hw_in_o), 32'(v));
    end
    @(negedge clk_i); pad_in_i = '0;
    cyc(3);

    // R5 filter on pin 0 with L=3, pin 1 unfiltered
    wr(A_FLTLEN, N'(3));
    wr(A_FLTEN, N'(1));
    @(negedge clk_i); pad_in_i = N'(3);
    cyc(3);
    chk("R5 unfiltered pin", 32'(hw_in_o[1]), 32'h1);
    ticks(3);
    @(negedge clk_i); pad_in_i = '0;
    cyc(3);
    ticks(1);
    rd(A_PIN, r);
    chk("R5 short glitch", 32'(r[0]), 32'h0);
    @(negedge clk_i); pad_in_i = N'(1);
    cyc(3);
    ticks(3);
    rd(A_PIN, r);
    chk("R5 count restarted", 32'(r[0]), 32'h0);
    ticks(1);
    rd(A_PIN, r);
    chk("R5 accepted after L+1", 32'(r[0]), 32'h1);
    @(negedge clk_i); pad_in_i = '0;
    cyc(3);
    ticks(4);
    wr(A_FLTEN, '0);

    // clear all pending status
    cyc(4);
    wr(A_ISTAT, '1);
    rd(A_ISTAT, r);
    chk("R8 clear all", 32'(r), 32'h0);

    // R6 edge, R9 masking
    wr(A_IPOL, '1);
    wr(A_IEN, N'(1));
    @(negedge clk_i); pad_in_i = N'(1);
    cyc(4);
    rd(A_ISTAT, r);
    chk("R6 rising", 32'(r), 32'h1);
    chk("R9 irq on", 32'(irq_o), 32'h1);
    cyc(5);
    chk("R8 sticky", 32'(irq_o), 32'h1);
    wr(A_ISTAT, N'(8'hFE));
    rd(A_ISTAT, r);
    chk("R8 write zero no effect", 32'(r), 32'h1);
    wr(A_ISTAT, N'(1));
    rd(A_ISTAT, r);
    chk("R8 w1c", 32'(r), 32'h0);
    chk("R9 irq off", 32'(irq_o), 32'h0);
    @(negedge clk_i); pad_in_i = N'(5);
    cyc(4);
    rd(A_ISTAT, r);
    chk("R9 masked stat", 32'(r), 32'h4);
    chk("R9 masked irq", 32'(irq_o), 32'h0);
    @(negedge clk_i); pad_in_i = N'(4);
    cyc(4);
    rd(A_ISTAT, r);
    chk("R6 falling ignored", 32'(r), 32'h4);
    wr(A_IPOL, N'(8'hFB));
    @(negedge clk_i); pad_in_i = '0;
    cyc(4);
    rd(A_ISTAT, r);
    chk("R6 falling pol", 32'(r), 32'h4);
    wr(A_ISTAT, '1);
    wr(A_IPOL, '1);

    // R7 level
    wr(A_ITYPE, N'(8));
    cyc(2);
    rd(A_ISTAT, r);
    chk("R7 level inactive", 32'(r), 32'h0);
    @(negedge clk_i); pad_in_i = N'(8);
    cyc(4);
    rd(A_ISTAT, r);
    chk("R7 level set", 32'(r), 32'h8);
    wr(A_ISTAT, N'(8));
    rd(A_ISTAT, r);
    chk("R7 clear while held", 32'(r), 32'h8);
    @(negedge clk_i); pad_in_i = '0;
    cyc(4);
    wr(A_ISTAT, N'(8));
    rd(A_ISTAT, r);
    chk("R7 clear after release", 32'(r), 32'h0);
    wr(A_ITYPE, '0);
    wr(A_IEN, '0);

    // R10 wake sweep, independent of irq setup
    wr(A_IEN, '1);
    for (int k = 0; k < 32; k++) begin
      logic [N-1:0] e, l, p;
      e = N'(k * 19 + 1); l = N'(k * 101);
      wr(A_WEN, e); wr(A_WLVL, l);
      for (int j = 0; j < 4; j++) begin
        p = N'(k * 7 + j * 67);
        pad_in_i = p;
        #1;
        chk("R10 wake", 32'(wake_o), 32'(|(e & ~(p ^ l))));
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule